// File: doc/BRIEF.md
# GPIO Interrupt Trigger Unit

This block turns the sampled levels of a bank of general-purpose input pins into latched interrupt status and a single combined interrupt request. Each pin is configured on its own. A pin can trigger on a rising edge, a falling edge, either edge, a high level or a low level. It has an enable bit that allows it to record events and a mask bit that stops a recorded event from reaching the combined request. Software sees the raw status and the masked status as separate read-only words. It acknowledges edge events by writing ones to a clear word.

The unit sits behind a plain word-addressed register port with an address, a write strobe, write data and combinational read data. Its pin inputs must already be synchronised to the clock. Edge detection compares each pin with its value on the previous clock. That previous value is captured on every cycle, whatever the pin's configuration. The combined request is a registered OR of all masked status bits.

Top module: `gpio_irq_trigger`

## Requirements
- R1: After reset every configuration word and every status bit is 0 and `irq_out` is low.
- R2: The configuration words read back what was last written at these byte offsets: 0x20 enable, 0x2C mask, 0x34 type, 0x38 both-edge, 0x3C polarity. Raw status reads at 0x24 and masked status at 0x28. The clear word (0x30) and all unused offsets read 0. Bit i of every word belongs to pin i.
- R3: An enabled pin with type bit 0 (edge), both-edge bit 0 and polarity bit 0 sets its raw status on the clock where it is first seen high after being low.
- R4: With type 0, both-edge 0 and polarity 1, a high-to-low transition sets the status and a low-to-high transition does not.
- R5: With type 0 and both-edge 1, either transition sets the status, whatever the polarity bit holds.
- R6: With type bit 1 (level), the raw status on each clock equals enable AND the active level, where polarity 0 is active-high and polarity 1 is active-low. The status drops when the level goes inactive. A clear written while the level is active leaves the status at 1.
- R7: For edge pins, writing 1 to a clear bit at 0x30 drops that pin's latched status on the next clock. Writing 0 has no effect. An edge that arrives in the same cycle as the clear wins, and the status stays 1.
- R8: A pin whose enable bit is 0 never sets its status bit.
- R9: The masked status is the raw status AND NOT mask. A mask bit of 1 keeps the pin out of the masked status and out of `irq_out`.
- R10: `irq_out` is the OR of the masked status, registered. It rises one clock after a masked status bit sets and falls one clock after the last one clears.
- R11: The previous-sample register is updated on every clock, even for disabled pins. A pin that is already high when it is enabled therefore produces no rising-edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| pin_in | input | N_PINS (32) | Synchronised pin levels |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
On every cycle, the assertions check five things: configuration write-back, the level-mode status following enable and level, the clearing of an edge status when no new edge is present, disabled pins that stay clear, and `irq_out` lagging the OR of the masked status by exactly one clock. The choice between rising, falling and both-edge triggering, the same-cycle race between a set and a clear, and the effect of a pin that is already high when its enable arrives only appear in the bench's scenarios. The bench covers these with directed sequences on a single pin and with a long randomized run in which pins, configuration and clears all change together against a reference model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned OFS_ENABLE = 'h20;
   localparam int unsigned OFS_RAW    = 'h24;
   localparam int unsigned OFS_MASKED = 'h28;
   localparam int unsigned OFS_MASK   = 'h2C;
   localparam int unsigned OFS_CLEAR  = 'h30;
   localparam int unsigned OFS_TYPE   = 'h34;
   localparam int unsigned OFS_BOTH   = 'h38;
   localparam int unsigned OFS_POL    = 'h3C;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_ENABLE, SEL_MASK, SEL_CLEAR, SEL_TYPE, SEL_BOTH, SEL_POL
   } wr_sel_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int N_PINS = 32,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_PINS-1:0] raw_stat,
   input  logic [N_PINS-1:0] masked_stat,
   output logic [N_PINS-1:0] cfg_en,
   output logic [N_PINS-1:0] cfg_mask,
   output logic [N_PINS-1:0] cfg_type,
   output logic [N_PINS-1:0] cfg_both,
   output logic [N_PINS-1:0] cfg_pol,
   output logic [N_PINS-1:0] clr_pulse
);
   wr_sel_e           sel;
   logic [N_PINS-1:0] wbits;

   assign wbits = reg_wdata[N_PINS-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (reg_wr) begin
         case (int'(reg_addr))
            OFS_ENABLE: sel = SEL_ENABLE;
            OFS_MASK:   sel = SEL_MASK;
            OFS_CLEAR:  sel = SEL_CLEAR;
            OFS_TYPE:   sel = SEL_TYPE;
            OFS_BOTH:   sel = SEL_BOTH;
            OFS_POL:    sel = SEL_POL;
            default:    sel = SEL_NONE;
         endcase
      end
   end

   assign clr_pulse = (sel == SEL_CLEAR) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en   <= '0;
         cfg_mask <= '0;
         cfg_type <= '0;
         cfg_both <= '0;
         cfg_pol  <= '0;
      end else begin
         case (sel)
            SEL_ENABLE: cfg_en   <= wbits;
            SEL_MASK:   cfg_mask <= wbits;
            SEL_TYPE:   cfg_type <= wbits;
            SEL_BOTH:   cfg_both <= wbits;
            SEL_POL:    cfg_pol  <= wbits;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (int'(reg_addr))
         OFS_ENABLE: reg_rdata = DATA_W'(cfg_en);
         OFS_RAW:    reg_rdata = DATA_W'(raw_stat);
         OFS_MASKED: reg_rdata = DATA_W'(masked_stat);
         OFS_MASK:   reg_rdata = DATA_W'(cfg_mask);
         OFS_TYPE:   reg_rdata = DATA_W'(cfg_type);
         OFS_BOTH:   reg_rdata = DATA_W'(cfg_both);
         OFS_POL:    reg_rdata = DATA_W'(cfg_pol);
         default:    reg_rdata = '0;
      endcase
   end

   // R2: a configuration write is visible on the following cycle
   assert_en_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && int'(reg_addr) == OFS_ENABLE) |=> cfg_en == $past(wbits));
   assert_type_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && int'(reg_addr) == OFS_TYPE) |=> cfg_type == $past(wbits));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int N_PINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_in,
   input  logic [N_PINS-1:0] cfg_en,
   input  logic [N_PINS-1:0] cfg_type,
   input  logic [N_PINS-1:0] cfg_both,
   input  logic [N_PINS-1:0] cfg_pol,
   input  logic [N_PINS-1:0] clr_pulse,
   output logic [N_PINS-1:0] raw_stat
);
   logic [N_PINS-1:0] prev_q;
   logic [N_PINS-1:0] rise, fall, edge_hit, lvl_act;

   // R11: history is taken every cycle, independent of enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_in;
   end

   assign rise = pin_in & ~prev_q;
   assign fall = ~pin_in & prev_q;

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      always_comb begin
         edge_hit[i] = cfg_both[i] ? (rise[i] | fall[i])
                                   : (cfg_pol[i] ? fall[i] : rise[i]);
         lvl_act[i]  = cfg_pol[i] ? ~pin_in[i] : pin_in[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            raw_stat[i] <= 1'b0;
         else if (cfg_type[i])
            raw_stat[i] <= cfg_en[i] & lvl_act[i];
         else if (cfg_en[i] & edge_hit[i])
            raw_stat[i] <= 1'b1;
         else if (clr_pulse[i])
            raw_stat[i] <= 1'b0;
      end

      // R8: a disabled pin cannot raise its status
      assert_dis_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_en[i] && !raw_stat[i]) |=> !raw_stat[i]);
      // R6: level status follows enable and active level
      assert_lvl_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_type[i] |=> raw_stat[i] == $past(cfg_en[i] & (pin_in[i] ^ cfg_pol[i])));
      // R7: clear drops an edge status when no edge competes
      assert_clr_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_type[i] && clr_pulse[i] && !(cfg_en[i] && edge_hit[i])) |=> !raw_stat[i]);
   end
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
   parameter int N_PINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] raw_stat,
   input  logic [N_PINS-1:0] cfg_mask,
   output logic [N_PINS-1:0] masked_stat,
   output logic              irq_out
);
   assign masked_stat = raw_stat & ~cfg_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= 1'b0;
      else        irq_out <= |masked_stat;
   end

   // R10: request follows the masked status by one clock
   assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|(raw_stat & ~cfg_mask)) |=> irq_out);
   assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(raw_stat & ~cfg_mask)) |=> !irq_out);
endmodule

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger #(
   parameter int N_PINS = 32,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_PINS-1:0] pin_in,
   output logic              irq_out
);
   localparam int MIN_ADDR_W = 6;

   if (N_PINS < 1 || N_PINS > DATA_W) begin : g_bad_pins
      $error("N_PINS must lie between 1 and DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end

   logic [N_PINS-1:0] cfg_en, cfg_mask, cfg_type, cfg_both, cfg_pol;
   logic [N_PINS-1:0] clr_pulse, raw_stat, masked_stat;

   gpio_irq_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raw_stat(raw_stat),
      .masked_stat(masked_stat), .cfg_en(cfg_en), .cfg_mask(cfg_mask),
      .cfg_type(cfg_type), .cfg_both(cfg_both), .cfg_pol(cfg_pol),
      .clr_pulse(clr_pulse)
   );

   gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_en(cfg_en),
      .cfg_type(cfg_type), .cfg_both(cfg_both), .cfg_pol(cfg_pol),
      .clr_pulse(clr_pulse), .raw_stat(raw_stat)
   );

   gpio_irq_combine #(.N_PINS(N_PINS)) u_combine (
      .clk(clk), .rst_n(rst_n), .raw_stat(raw_stat), .cfg_mask(cfg_mask),
      .masked_stat(masked_stat), .irq_out(irq_out)
   );
endmodule

// File: tb/tb_gpio_irq_trigger.sv
module tb_gpio_irq_trigger;
   localparam int N = 32;
   localparam logic [7:0] A_EN = 8'h20, A_RAW = 8'h24, A_MSKD = 8'h28, A_MASK = 8'h2C,
                          A_CLR = 8'h30, A_TYPE = 8'h34, A_BOTH = 8'h38, A_POL = 8'h3C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  pin_in = '0;
   logic          irq_out;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   logic [N-1:0] m_en, m_mask, m_type, m_both, m_pol, m_raw, m_prev;
   logic         m_irq;

   always #4 clk = ~clk;

   gpio_irq_trigger dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .irq_out(irq_out)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] next_raw(logic [N-1:0] pins, logic [N-1:0] clr);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         logic rs, fl, hit;
         rs  = pins[i] & ~m_prev[i];
         fl  = ~pins[i] & m_prev[i];
         hit = m_both[i] ? (rs | fl) : (m_pol[i] ? fl : rs);
         if (m_type[i])                 r[i] = m_en[i] & (m_pol[i] ? ~pins[i] : pins[i]);
         else if (m_en[i] && hit)       r[i] = 1'b1;
         else if (clr[i])               r[i] = 1'b0;
         else                           r[i] = m_raw[i];
      end
      return r;
   endfunction

   task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
      reg_wr = 1'b0;
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   // One clock: drive, update model, advance, compare irq, raw and masked.
   task automatic step(string req, logic [N-1:0] pins, bit wr = 0,
                       logic [7:0] a = 8'h00, logic [31:0] d = '0);
      logic [N-1:0] clr, nraw;
      pin_in = pins; reg_wr = wr; reg_addr = a; reg_wdata = d;
      clr   = (wr && a == A_CLR) ? d[N-1:0] : '0;
      nraw  = next_raw(pins, clr);
      m_irq = |(m_raw & ~m_mask);
      m_raw = nraw;
      m_prev = pins;
      if (wr) begin
         case (a)
            A_EN:   m_en   = d[N-1:0];
            A_MASK: m_mask = d[N-1:0];
            A_TYPE: m_type = d[N-1:0];
            A_BOTH: m_both = d[N-1:0];
            A_POL:  m_pol  = d[N-1:0];
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
      chk({req, " irq"}, 32'(irq_out), 32'(m_irq));
      rd({req, " raw"}, A_RAW, m_raw);
      rd({req, " masked"}, A_MSKD, m_raw & ~m_mask);
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [N-1:0] p;
      void'($urandom(32'd20240611));
      {m_en, m_mask, m_type, m_both, m_pol, m_raw, m_prev} = '0;
      m_irq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq_out), 0);
      rd("R1 en", A_EN, 0);   rd("R1 raw", A_RAW, 0);
      rd("R1 type", A_TYPE, 0); rd("R1 pol", A_POL, 0);

      // R8: toggle pin 0 while disabled
      step("R8", 32'h1);
      rd("R8 raw zero", A_RAW, 0);
      // R11: enable with pin 0 already high, then hold
      step("R11", 32'h1, 1, A_EN, 32'hFFFF_FFFF);
      rd("R2 enable readback", A_EN, 32'hFFFF_FFFF);
      step("R11", 32'h1);
      rd("R11 no rising event", A_RAW, 0);

      // R3 rising edge on pin 3, R10 latency
      step("R3", 32'h9);
      rd("R3 rise latched", A_RAW, 32'h8);
      chk("R10 irq not yet", 32'(irq_out), 0);
      step("R10", 32'h9);
      chk("R10 irq one cycle later", 32'(irq_out), 1);
      rd("R9 masked visible", A_MSKD, 32'h8);

      // R9 mask blocks
      step("R9", 32'h9, 1, A_MASK, 32'h8);
      rd("R9 masked blocked", A_MSKD, 0);
      step("R9", 32'h9);
      chk("R9 irq blocked", 32'(irq_out), 0);
      step("R9", 32'h9, 1, A_MASK, 32'h0);

      // R7 clear with zero, then with one
      step("R7", 32'h9, 1, A_CLR, 32'h0);
      rd("R7 zero write keeps", A_RAW, 32'h8);
      step("R7", 32'h9, 1, A_CLR, 32'h8);
      rd("R7 one write clears", A_RAW, 0);
      rd("R2 clear reads zero", A_CLR, 0);
      rd("R2 unused reads zero", 8'h00, 0);

      // R4 falling only
      step("R4", 32'h9, 1, A_POL, 32'h8);
      step("R4", 32'h1);
      rd("R4 fall latched", A_RAW, 32'h8);
      step("R4", 32'h1, 1, A_CLR, 32'h8);
      step("R4", 32'h9);
      rd("R4 rise ignored", A_RAW, 0);

      // R5 both edges regardless of polarity
      step("R5", 32'h9, 1, A_BOTH, 32'h8);
      step("R5", 32'h1);
      rd("R5 fall", A_RAW, 32'h8);
      step("R5", 32'h1, 1, A_CLR, 32'h8);
      step("R5", 32'h9);
      rd("R5 rise", A_RAW, 32'h8);
      step("R5", 32'h9, 1, A_CLR, 32'h8);

      // R6 level high, then low
      step("R6", 32'h9, 1, A_TYPE, 32'h8);
      step("R6", 32'h9, 1, A_POL, 32'h0);
      step("R6", 32'h9);
      rd("R6 high active", A_RAW, 32'h8);
      step("R6", 32'h9, 1, A_CLR, 32'h8);
      rd("R6 clear while active", A_RAW, 32'h8);
      step("R6", 32'h1);
      rd("R6 drops when inactive", A_RAW, 0);
      step("R6", 32'h1, 1, A_POL, 32'h8);
      step("R6", 32'h1);
      rd("R6 low active", A_RAW, 32'h8);

      // R7 set beats clear in the same cycle
      step("R7", 32'h1, 1, A_TYPE, 32'h0);
      step("R7", 32'h1, 1, A_BOTH, 32'h0);
      step("R7", 32'h1, 1, A_POL, 32'h0);
      step("R7", 32'h1, 1, A_CLR, 32'h8);
      step("R7", 32'h9, 1, A_CLR, 32'h8);
      rd("R7 set wins", A_RAW, 32'h8);

      // Random mix (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 via model)
      for (int k = 0; k < 3000; k++) begin
         int sel;
         p = ($urandom % 4 == 0) ? $urandom : pin_in ^ ($urandom & $urandom & $urandom);
         sel = $urandom % 12;
         case (sel)
            0: step("R8 rnd", p, 1, A_EN, $urandom);
            1: step("R9 rnd", p, 1, A_MASK, $urandom);
            2: step("R6 rnd", p, 1, A_TYPE, $urandom);
            3: step("R5 rnd", p, 1, A_BOTH, $urandom);
            4: step("R4 rnd", p, 1, A_POL, $urandom);
            5, 6: step("R7 rnd", p, 1, A_CLR, $urandom);
            default: step("R3 R10 R11 rnd", p);
         endcase
         if (k % 50 == 0) begin
            rd("R2 rnd en", A_EN, m_en);   rd("R2 rnd mask", A_MASK, m_mask);
            rd("R2 rnd type", A_TYPE, m_type); rd("R2 rnd both", A_BOTH, m_both);
            rd("R2 rnd pol", A_POL, m_pol);
         end
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule